// File: doc/BRIEF.md
# Function-Unit Register Dependency Matrix with Rename Bits

This block keeps a bit matrix in which each row stands for one function unit and each column for one architectural register. When an instruction is issued to a unit, that unit's row records the registers it still has to read and the register it will write. From these flags the block decides, for every unit, when it may read its operands and when it may deliver its result. The read and write requests it sends to the register file are one enable line per register.

Every register column also holds a "newest writer" bit, and at most one row may own it. A source operand waits only on the unit that owns the newest-writer bit of that register. When a new instruction writes the register, the bit moves to the new unit's row. Older writers then stop blocking later readers. This gives register renaming inside the matrix itself, without an alias table or a separate physical register file. A unit is released when its write completes. A write-prevention input per unit can hold the write back until the unit knows that no exception will occur.

Top module: `fu_reg_depmatrix`

## Requirements
- R1: After reset, no unit is busy, no read or write flag is set and no newest-writer bit is set. As a result `goRead`, `goWrite`, `readEnable`, `writeEnable` and `latestMap` are all zero.
- R2: An issue to an idle unit (`issueValid` high and row `issueUnit` not busy) is accepted in the same cycle (`issueAccept` high). From the next cycle, the row holds its valid sources as read flags and its valid destination as a write flag.
- R3: In each register column, at most one unit row holds the newest-writer bit. `latestMap` bit `u*REGS+r` is that bit for unit u and register r. An accepted issue with a destination r sets bit (issued unit, r) and clears bit r in every other row, effective in the next cycle.
- R4: An accepted source register r makes the issued unit depend only on the unit that currently owns the newest-writer bit of r. A source identical to the issue's own destination depends on the previous owner. Older writers of r create no dependency.
- R5: `goRead[u]` is high when unit u is busy, has at least one read flag and depends on no unit. `readEnable[r]` is the OR, over units with `goRead`, of their read flag for r. `readDone[u]` together with `goRead[u]` clears the row's read flags in the next cycle.
- R6: `goWrite[u]` is high when unit u is busy, has no read flag left and `writeHold[u]` is low. `writeEnable[r]` is the OR, over units with `goWrite`, of their write flag for r.
- R7: `doneWrite[u]` together with `goWrite[u]` does four things in the next cycle: it frees the row, clears its write flags, clears its newest-writer bits, and removes every dependency other units hold on u.
- R8: An issue to a busy unit is refused (`issueAccept` low) and changes no flag, no dependency and no newest-writer bit.
- R9: An issue whose source's newest writer completes in the same cycle creates no dependency on that writer.
- R10: `readDone[u]` without `goRead[u]`, and `doneWrite[u]` without `goWrite[u]`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueUnit | input | UW | Target unit row |
| issueSrcValid | input | SRCS | Per-source valid |
| issueSrc | input | SRCS*RW | Source register indices, source s at bits s*RW |
| issueDstValid | input | 1 | Destination present |
| issueDst | input | RW | Destination register index |
| issueAccept | output | 1 | Issue taken this cycle |
| readDone | input | UNITS | Unit has captured its operands |
| doneWrite | input | UNITS | Unit has written its result |
| writeHold | input | UNITS | Write prevention per unit |
| goRead | output | UNITS | Read permission per unit |
| goWrite | output | UNITS | Write permission per unit |
| readEnable | output | REGS | Register read enables |
| writeEnable | output | REGS | Register write enables |
| latestMap | output | UNITS*REGS | Newest-writer bits, unit-major |

## Verification
`issueAccept`, the grants and the enables are combinational. They are due in the same cycle as the inputs that cause them, and they also follow matrix state registered one edge earlier. Any issue, read release or completion therefore shows at the ports one clock edge after it is applied. The bench drives inputs just after the falling edge and samples every output shortly after that, before the next rising edge. It then advances its own model of the matrix across that edge, so each expected value is compared in exactly the cycle it is due.

// File: rtl/fudm_pkg.sv
package fudm_pkg;
  localparam int DEF_UNITS = 4;
  localparam int DEF_REGS  = 8;
  localparam int DEF_SRCS  = 2;

  function automatic int idxWidth(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/fudm_grant.sv
module fudm_grant #(
  parameter int UNITS = 4,
  parameter int UW = 2,
  parameter type strobeT = logic
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  input  logic [UW-1:0]    issueUnit,
  input  logic [UNITS-1:0] readDone,
  input  logic [UNITS-1:0] doneWrite,
  input  logic [UNITS-1:0] writeHold,
  input  logic [UNITS-1:0] busy,
  input  logic [UNITS-1:0] readPend,
  input  logic [UNITS-1:0] waitAny,
  output logic             issueAccept,
  output logic [UNITS-1:0] goRead,
  output logic [UNITS-1:0] goWrite,
  output strobeT           strb
);
  logic targetFree;

  always_comb begin
    targetFree = 1'b0;
    for (int u = 0; u < UNITS; u++)
      if (issueUnit == UW'(u)) targetFree = !busy[u];
  end

  assign issueAccept = issueValid && targetFree;
  assign goRead  = busy & readPend & ~waitAny;
  assign goWrite = busy & ~readPend & ~writeHold;

  always_comb begin
    strb = '0;
    for (int u = 0; u < UNITS; u++)
      strb.issueRow[u] = issueAccept && (issueUnit == UW'(u));
    strb.readClr  = readDone & goRead;
    strb.writeClr = doneWrite & goWrite;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_chk
    // R5: once operands are released the row asks for no further reads
    a_r5_read_once: assert property (@(posedge clk) disable iff (!rst_n)
      strb.readClr[u] |=> !goRead[u]);
    // R8: a busy row never receives an issue strobe
    a_r8_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
      busy[u] |-> !strb.issueRow[u]);
  end
endmodule

// File: rtl/fudm_matrix.sv
module fudm_matrix #(
  parameter int UNITS = 4,
  parameter int REGS = 8,
  parameter int SRCS = 2,
  parameter int RW = 3,
  parameter type strobeT = logic
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobeT                strb,
  input  logic [SRCS-1:0]       srcValid,
  input  logic [SRCS*RW-1:0]    srcIdx,
  input  logic                  dstValid,
  input  logic [RW-1:0]         dstIdx,
  input  logic [UNITS-1:0]      goRead,
  input  logic [UNITS-1:0]      goWrite,
  output logic [UNITS-1:0]      busy,
  output logic [UNITS-1:0]      readPend,
  output logic [UNITS-1:0]      waitAny,
  output logic [REGS-1:0]       readEnable,
  output logic [REGS-1:0]       writeEnable,
  output logic [UNITS*REGS-1:0] latestFlat
);
  logic [UNITS-1:0][REGS-1:0]  needRead, needWrite, latest;
  logic [UNITS-1:0][UNITS-1:0] waitOn;
  logic [REGS-1:0]  srcMask, dstMask;
  logic [UNITS-1:0] producers;
  logic             issueHit;

  assign issueHit = |strb.issueRow;

  always_comb begin
    srcMask = '0;
    dstMask = '0;
    for (int r = 0; r < REGS; r++) begin
      for (int s = 0; s < SRCS; s++)
        if (srcValid[s] && srcIdx[s*RW +: RW] == RW'(r)) srcMask[r] = 1'b1;
      dstMask[r] = dstValid && (dstIdx == RW'(r));
    end
  end

  // dependency goes only to the current newest writer, unless it retires now
  always_comb begin
    for (int v = 0; v < UNITS; v++)
      producers[v] = (|(latest[v] & srcMask)) && !strb.writeClr[v];
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[u]      <= 1'b0;
        needRead[u]  <= '0;
        needWrite[u] <= '0;
        latest[u]    <= '0;
        waitOn[u]    <= '0;
      end else if (strb.issueRow[u]) begin
        busy[u]      <= 1'b1;
        needRead[u]  <= srcMask;
        needWrite[u] <= dstMask;
        latest[u]    <= dstMask;
        waitOn[u]    <= producers;
      end else begin
        if (strb.readClr[u]) needRead[u] <= '0;
        if (strb.writeClr[u]) begin
          busy[u]      <= 1'b0;
          needWrite[u] <= '0;
          latest[u]    <= '0;
        end else if (issueHit) begin
          latest[u] <= latest[u] & ~dstMask;
        end
        waitOn[u] <= waitOn[u] & ~strb.writeClr;
      end
    end

    assign readPend[u] = |needRead[u];
    assign waitAny[u]  = |waitOn[u];

    logic [UNITS-1:0] waitCol;
    always_comb
      for (int w = 0; w < UNITS; w++) waitCol[w] = waitOn[w][u];

    // R7: completion frees the row and every dependant waiting on it
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      strb.writeClr[u] |=> !busy[u] && latest[u] == '0 && waitCol == '0);
    // R8: a busy row keeps its write flags until it completes
    a_r8_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
      busy[u] && !strb.writeClr[u] |=> busy[u] && $stable(needWrite[u]));
    // R2: an issued row is busy on the next cycle
    a_r2_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
      strb.issueRow[u] |=> busy[u]);
  end

  for (genvar r = 0; r < REGS; r++) begin : g_col
    logic [UNITS-1:0] colBits;
    always_comb
      for (int u = 0; u < UNITS; u++) colBits[u] = latest[u][r];
    // R3: newest-writer bit owned by at most one row
    a_r3_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colBits));
  end

  always_comb begin
    readEnable  = '0;
    writeEnable = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (goRead[u])  readEnable  = readEnable  | needRead[u];
      if (goWrite[u]) writeEnable = writeEnable | needWrite[u];
    end
  end

  assign latestFlat = latest;
endmodule

// File: rtl/fu_reg_depmatrix.sv
module fu_reg_depmatrix #(
  parameter int UNITS = fudm_pkg::DEF_UNITS,
  parameter int REGS  = fudm_pkg::DEF_REGS,
  parameter int SRCS  = fudm_pkg::DEF_SRCS,
  localparam int UW = fudm_pkg::idxWidth(UNITS),
  localparam int RW = fudm_pkg::idxWidth(REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issueValid,
  input  logic [UW-1:0]         issueUnit,
  input  logic [SRCS-1:0]       issueSrcValid,
  input  logic [SRCS*RW-1:0]    issueSrc,
  input  logic                  issueDstValid,
  input  logic [RW-1:0]         issueDst,
  output logic                  issueAccept,
  input  logic [UNITS-1:0]      readDone,
  input  logic [UNITS-1:0]      doneWrite,
  input  logic [UNITS-1:0]      writeHold,
  output logic [UNITS-1:0]      goRead,
  output logic [UNITS-1:0]      goWrite,
  output logic [REGS-1:0]       readEnable,
  output logic [REGS-1:0]       writeEnable,
  output logic [UNITS*REGS-1:0] latestMap
);
  typedef struct packed {
    logic [UNITS-1:0] issueRow;
    logic [UNITS-1:0] readClr;
    logic [UNITS-1:0] writeClr;
  } strobeT;

  strobeT strb;
  logic [UNITS-1:0] busy, readPend, waitAny;

  fudm_grant #(.UNITS(UNITS), .UW(UW), .strobeT(strobeT)) u_grant (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueUnit(issueUnit),
    .readDone(readDone), .doneWrite(doneWrite), .writeHold(writeHold),
    .busy(busy), .readPend(readPend), .waitAny(waitAny),
    .issueAccept(issueAccept), .goRead(goRead), .goWrite(goWrite),
    .strb(strb)
  );

  fudm_matrix #(.UNITS(UNITS), .REGS(REGS), .SRCS(SRCS), .RW(RW),
                .strobeT(strobeT)) u_matrix (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .srcValid(issueSrcValid), .srcIdx(issueSrc),
    .dstValid(issueDstValid), .dstIdx(issueDst),
    .goRead(goRead), .goWrite(goWrite),
    .busy(busy), .readPend(readPend), .waitAny(waitAny),
    .readEnable(readEnable), .writeEnable(writeEnable),
    .latestFlat(latestMap)
  );
endmodule

// File: tb/sim_fu_reg_depmatrix.sv
module sim_fu_reg_depmatrix;
  localparam int NU = 4, NR = 8, NS = 2, UW = 2, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issueValid, issueDstValid, issueAccept;
  logic [UW-1:0] issueUnit;
  logic [NS-1:0] issueSrcValid;
  logic [NS*RW-1:0] issueSrc;
  logic [RW-1:0] issueDst;
  logic [NU-1:0] readDone, doneWrite, writeHold, goRead, goWrite;
  logic [NR-1:0] readEnable, writeEnable;
  logic [NU*NR-1:0] latestMap;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fu_reg_depmatrix u0 (.*);

  logic          mBusy [NU];
  logic [NR-1:0] mNR [NU], mNW [NU], mLat [NU];
  logic [NU-1:0] mWait [NU];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NU-1:0] expGoRead();
    for (int u = 0; u < NU; u++)
      expGoRead[u] = mBusy[u] && (mNR[u] != 0) && (mWait[u] == 0);
  endfunction

  function automatic logic [NU-1:0] expGoWrite();
    for (int u = 0; u < NU; u++)
      expGoWrite[u] = mBusy[u] && (mNR[u] == 0) && !writeHold[u];
  endfunction

  function automatic logic [NR-1:0] decodeSrc();
    logic [NR-1:0] m = '0;
    for (int s = 0; s < NS; s++)
      if (issueSrcValid[s]) m[issueSrc[s*RW +: RW]] = 1'b1;
    return m;
  endfunction

  task automatic modelReset();
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mNR[u] = '0; mNW[u] = '0; mLat[u] = '0; mWait[u] = '0;
    end
  endtask

  task automatic idle();
    issueValid = 0; issueUnit = '0; issueSrcValid = '0; issueSrc = '0;
    issueDstValid = 0; issueDst = '0; readDone = '0; doneWrite = '0;
    writeHold = '0;
  endtask

  task automatic step();
    logic [NU-1:0] gr, gw, rc, wc, prod;
    logic [NR-1:0] sm, dm, re, we;
    logic [NU*NR-1:0] lm;
    bit acc;
    #1;
    gr = expGoRead(); gw = expGoWrite();
    acc = issueValid && !mBusy[issueUnit];
    re = '0; we = '0; lm = '0;
    for (int u = 0; u < NU; u++) begin
      if (gr[u]) re |= mNR[u];
      if (gw[u]) we |= mNW[u];
      lm[u*NR +: NR] = mLat[u];
    end
    chk(issueAccept == acc, "R2/R8", "issueAccept", 64'(issueAccept), 64'(acc));
    chk(goRead == gr, "R4/R5", "goRead", 64'(goRead), 64'(gr));
    chk(goWrite == gw, "R6", "goWrite", 64'(goWrite), 64'(gw));
    chk(readEnable == re, "R5", "readEnable", 64'(readEnable), 64'(re));
    chk(writeEnable == we, "R6", "writeEnable", 64'(writeEnable), 64'(we));
    chk(latestMap == lm, "R3", "latestMap", 64'(latestMap), 64'(lm));
    // next model state (R7 R9 R10: grant-qualified strobes)
    rc = readDone & gr;
    wc = doneWrite & gw;
    sm = decodeSrc();
    dm = '0;
    if (issueDstValid) dm[issueDst] = 1'b1;
    for (int v = 0; v < NU; v++) prod[v] = ((mLat[v] & sm) != 0) && !wc[v];
    @(posedge clk);
    for (int u = 0; u < NU; u++) begin
      if (acc && issueUnit == UW'(u)) begin
        mBusy[u] = 1; mNR[u] = sm; mNW[u] = dm; mLat[u] = dm; mWait[u] = prod;
      end else begin
        if (rc[u]) mNR[u] = '0;
        if (wc[u]) begin
          mBusy[u] = 0; mNW[u] = '0; mLat[u] = '0;
        end else if (acc) mLat[u] &= ~dm;
        mWait[u] &= ~wc;
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic issue(input int unit, input int d, input int s0, input int s1);
    issueValid = 1; issueUnit = UW'(unit);
    issueDstValid = (d >= 0); issueDst = RW'(d < 0 ? 0 : d);
    issueSrcValid = {s1 >= 0, s0 >= 0};
    issueSrc = {RW'(s1 < 0 ? 0 : s1), RW'(s0 < 0 ? 0 : s0)};
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    idle();
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk(goRead == 0 && goWrite == 0 && readEnable == 0 && writeEnable == 0,
        "R1", "grants after reset", 64'({goRead, goWrite, readEnable, writeEnable}), 64'd0);
    chk(latestMap == 0, "R1", "latestMap after reset", 64'(latestMap), 64'd0);

    // directed rename sequence: unit2 = mul-0, unit1 = add-1, unit0 = add-0
    issue(2, 1, 2, 3); step();
    #1;
    chk(latestMap == 32'h0002_0000, "R3", "owner r1 after first write", 64'(latestMap), 64'h20000);
    chk(readEnable == 8'h0C, "R5", "read enables r2 r3", 64'(readEnable), 64'h0C);
    issue(0, 4, 1, 3); step();
    #1;
    chk(goRead == 4'b0100, "R4", "reader of r1 waits", 64'(goRead), 64'b0100);
    issue(1, 1, 5, 1); step();
    #1;
    chk(latestMap == 32'h0000_0210, "R3", "owner of r1 moved to unit1", 64'(latestMap), 64'h210);
    chk(goRead == 4'b0100, "R4", "own-dest source waits on old owner", 64'(goRead), 64'b0100);
    issue(0, 7, 6, -1);
    #1;
    chk(issueAccept == 0, "R8", "busy row refused", 64'(issueAccept), 64'd0);
    step();
    doneWrite = 4'b0100; step();   // not granted: ignored
    #1;
    chk(goWrite == 4'b0000, "R10", "early done ignored", 64'(goWrite), 64'd0);
    readDone = 4'b0100; step();
    #1;
    chk(goWrite == 4'b0100 && writeEnable == 8'h02, "R6", "unit2 may write r1",
        64'({goWrite, writeEnable}), 64'h402);
    writeHold = 4'b0100; #1;
    chk(goWrite == 4'b0000, "R6", "hold blocks write", 64'(goWrite), 64'd0);
    step();
    doneWrite = 4'b0100; issue(3, -1, 1, -1); step();  // R9 path is for unit1 owner
    #1;
    chk(goRead == 4'b0011, "R7", "dependants released", 64'(goRead), 64'b0011);
    chk(goRead[3] == 1'b0, "R4", "new reader of r1 waits on unit1", 64'(goRead[3]), 64'd0);
    // R9: producer completes while consumer issues
    readDone = 4'b0010; step();
    doneWrite = 4'b0010; issue(2, -1, 1, -1); step();
    #1;
    chk(goRead[2] == 1'b1, "R9", "no dependency on retiring writer", 64'(goRead[2]), 64'd1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(1, 0) == 1)
        issue(int'($urandom_range(NU - 1)),
              ($urandom_range(4) == 0) ? -1 : int'($urandom_range(NR - 1)),
              ($urandom_range(3) == 0) ? -1 : int'($urandom_range(NR - 1)),
              ($urandom_range(2) == 0) ? -1 : int'($urandom_range(NR - 1)));
      readDone  = NU'($urandom);
      doneWrite = NU'($urandom);
      for (int u = 0; u < NU; u++) writeHold[u] = ($urandom_range(3) == 0);
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule